// File: doc/BRIEF.md
# Bit-banged serial EEPROM target

This block answers a host that drives a two-wire serial bus by software, one register write at a time. Each write presents a new clock (SCL) and data (SDA) level together with a one-cycle strobe. The block compares the new pair against the pair it stored at the previous strobe. From that comparison it detects start and stop conditions and clock rising edges. The host reads back the SDA level the block stored, and that level may be a low the block drives itself.

After a start condition the block shifts in a control byte and then a word address, using one bit counter that spans both bytes. Each byte is acknowledged on the clock rise that follows it. When the control byte ends in a 1 (read), the block shifts out the byte fetched by the previous transaction, MSB first, during the address phase. When the eighth address bit arrives, the block fetches the byte at the accumulated address from a read-only image, acknowledges, and returns to idle. The image is computed from a seed parameter. There is no write path into the array.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset, sda_out is 1, no acknowledge is pending, and the block is idle.
- R2: A strobe that keeps SCL high while SDA goes from 1 to 0 is a start condition. It clears the command byte and arms the counter for the first command bit, and it does so even in the middle of a transaction.
- R3: While the block is idle and no acknowledge is pending, every strobe other than a start condition leaves the sequence state unchanged. Clock pulses then produce no acknowledge.
- R4: A clock rise on which SDA also differs from the stored level, with no acknowledge pending, is discarded and does not count as a bit.
- R5: The clock rise after the eighth command bit, and the clock rise after the eighth address bit, each set sda_out to 0 and clear the pending acknowledge without consuming a bit.
- R6: When the command LSB is 1, sda_out after each of the eight address-phase rises equals the next bit, MSB first, of the byte fetched by the previous transaction. That byte is 0 after reset.
- R7: On the eighth address bit the block latches the byte at that address, schedules an acknowledge, and returns to idle. Clock pulses after that acknowledge produce no further acknowledge.
- R8: A strobe that keeps SCL high while SDA goes from 0 to 1 is a stop condition. It leaves the bit counter, the command byte and the address unchanged.
- R9: Whenever the block does not drive the line, sda_out equals the SDA level of the most recent strobe. This includes the address phase of a command whose LSB is 0.
- R10: The byte stored at address a is (a*37 + SEED) mod 256, where SEED defaults to 0x5A. Only the low log2(DEPTH) address bits select the byte.
- R11: Cycles without wr_stb change neither sda_out nor the sequence state, whatever scl_in and sda_in do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a new host write of scl_in/sda_in |
| scl_in | input | 1 | Clock level written by the host |
| sda_in | input | 1 | Data level written by the host |
| sda_out | output | 1 | Line level stored by the block, as read back by the host |

## Verification
The hardest cases to reach from the ports are those where line conditions overlap the bit count. Examples are a clock rise that carries an SDA change, a stop condition in the middle of a command, and a restart after a partial command. Each of these shifts the acknowledge by one clock if it is handled wrongly. The bench reaches them through one transaction task that can inject an invalid edge, a stop condition or a restart at a chosen bit. Each time, it checks that the acknowledge still falls on the ninth valid rise. Read data can only be seen one transaction after its fetch, so every read is paired with a write-command transaction that fetches first.

// File: rtl/eep_pkg.sv
// Package for the serial EEPROM target: bus event codes, counter sizing,
// and the function that computes the preloaded image.
package eep_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 5;
    // Counter value while the last command bit is being taken.
    localparam int CMD_LAST  = 8;
    // Counter value while the last address bit is being taken.
    localparam int ADDR_LAST = 16;

    typedef enum logic [2:0] {
        EV_NONE,   // no host write this cycle
        EV_MOVE,   // host write with no meaning to the sequence
        EV_START,  // SDA fell while SCL stayed high
        EV_STOP,   // SDA rose while SCL stayed high
        EV_RISE    // SCL rose while a transaction or acknowledge is live
    } bus_ev_e;

    // Byte held at a given index of the read-only image.
    function automatic logic [BYTE_W-1:0] image_byte(int unsigned idx,
                                                     logic [BYTE_W-1:0] seed);
        return BYTE_W'(idx * 37 + int'(seed));
    endfunction

endpackage

// File: rtl/eep_bus_decode.sv
// Classifies each host write against the previously stored line pair.
// Assumes scl_q/sda_q hold the pair stored at the previous strobe.
module eep_bus_decode
    import eep_pkg::*;
(
    input  logic    stb,
    input  logic    scl_q,
    input  logic    sda_q,
    input  logic    scl_in,
    input  logic    sda_in,
    input  logic    busy,
    output bus_ev_e ev,
    output logic    lvl_same
);

    // Priority: line condition first, then idle filtering, then clock rise.
    always_comb begin
        lvl_same = (sda_q == sda_in);
        if (!stb)
            ev = EV_NONE;
        else if (scl_q && scl_in && !lvl_same)
            ev = sda_in ? EV_STOP : EV_START;
        else if (busy && !scl_q && scl_in)
            ev = EV_RISE;
        else
            ev = EV_MOVE;
    end

endmodule

// File: rtl/eep_rom.sv
// Read-only byte image, computed from SEED at elaboration.
// Assumes DEPTH is a power of two no larger than 256.
module eep_rom
    import eep_pkg::*;
#(
    parameter int                DEPTH = 256,
    parameter logic [BYTE_W-1:0] SEED  = 8'h5A
) (
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int AW = $clog2(DEPTH);

    logic [BYTE_W-1:0] image [DEPTH];

    // One constant entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign image[i] = image_byte(i, SEED);
    end

    // Asynchronous lookup on the low address bits.
    assign rd_data = image[rd_addr[AW-1:0]];

endmodule

// File: rtl/eep_seq.sv
// Bit sequencer: one counter spans the command byte and the address byte.
// It schedules the acknowledges and decides when the line is driven.
// Assumes ev comes from eep_bus_decode in the same cycle.
module eep_seq
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_e           ev,
    input  logic              lvl_same,
    input  logic              bit_in,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              drv_en,
    output logic              drv_val,
    output logic              busy,
    output logic [CNT_W-1:0]  tick,
    output logic              ack_pend
);

    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    logic in_cmd;
    logic take_bit;

    assign busy     = (tick != '0) || ack_pend;
    assign in_cmd   = (tick <= CNT_W'(CMD_LAST));
    assign take_bit = (ev == EV_RISE) && !ack_pend && lvl_same;
    assign rd_addr  = {addr_q[BYTE_W-2:0], bit_in};

    // Line override: acknowledge low, or read data during the address phase.
    always_comb begin
        drv_en  = 1'b0;
        drv_val = 1'b0;
        if (ev == EV_RISE) begin
            if (ack_pend) begin
                drv_en  = 1'b1;
                drv_val = 1'b0;
            end else if (lvl_same && !in_cmd && cmd_q[0]) begin
                drv_en  = 1'b1;
                drv_val = data_q[BYTE_W-1];
            end
        end
    end

    // Counter, shift registers, fetch and acknowledge scheduling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            ack_pend <= 1'b0;
        end else if (ev == EV_START) begin
            tick  <= CNT_W'(1);
            cmd_q <= '0;
        end else if (ev == EV_RISE && ack_pend) begin
            ack_pend <= 1'b0;
        end else if (take_bit && in_cmd) begin
            cmd_q <= {cmd_q[BYTE_W-2:0], bit_in};
            tick  <= tick + 1'b1;
            if (tick == CNT_W'(CMD_LAST))
                ack_pend <= 1'b1;
        end else if (take_bit) begin
            addr_q <= rd_addr;
            if (tick == CNT_W'(ADDR_LAST)) begin
                data_q   <= rom_data;
                ack_pend <= 1'b1;
                tick     <= '0;
            end else begin
                data_q <= {data_q[BYTE_W-2:0], 1'b0};
                tick   <= tick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/eep_i2c_target.sv
// Top of the bit-banged serial EEPROM target. It holds the stored line pair
// and ties the decoder, the sequencer and the image together.
// Assumes wr_stb is high for exactly one cycle per host write.
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter int                DEPTH = 256,
    parameter logic [BYTE_W-1:0] SEED  = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);

    logic              scl_q;
    logic              sda_q;
    bus_ev_e           ev;
    logic              lvl_same;
    logic              busy;
    logic              drv_en;
    logic              drv_val;
    logic [CNT_W-1:0]  tick;
    logic              ack_pend;
    logic [BYTE_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rom_data;

    eep_bus_decode u_decode (
        .stb      (wr_stb),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .busy     (busy),
        .ev       (ev),
        .lvl_same (lvl_same)
    );

    eep_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .lvl_same (lvl_same),
        .bit_in   (sda_in),
        .rom_data (rom_data),
        .rd_addr  (rd_addr),
        .drv_en   (drv_en),
        .drv_val  (drv_val),
        .busy     (busy),
        .tick     (tick),
        .ack_pend (ack_pend)
    );

    eep_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
        .rd_addr (rd_addr),
        .rd_data (rom_data)
    );

    // Store the host pair on each write; the block's own drive wins on SDA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (wr_stb) begin
            scl_q <= scl_in;
            sda_q <= drv_en ? drv_val : sda_in;
        end
    end

    assign sda_out = sda_q;

endmodule

// File: rtl/eep_i2c_target_chk.sv
// Property checker for eep_i2c_target, attached through bind.
// Assumes it sees the top's stored line pair, counter and acknowledge flag.
module eep_i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       scl_in,
    input logic       sda_in,
    input logic       scl_q,
    input logic       sda_out,
    input logic       ack_pend,
    input logic [4:0] tick
);

    logic start_c;
    logic rise_c;
    assign start_c = wr_stb && scl_q && scl_in && sda_out && !sda_in;
    assign rise_c  = wr_stb && !scl_q && scl_in;

    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> tick == 5'd1);

    p_idle_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tick == 5'd0 && !ack_pend && !start_c) |=> (tick == 5'd0 && !ack_pend));

    p_bad_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c && !ack_pend && tick != 5'd0 && sda_out != sda_in) |=> $stable(tick));

    p_ack_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c && ack_pend) |=> (!sda_out && !ack_pend && $stable(tick)));

    p_fetch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c && !ack_pend && tick == 5'd16 && sda_out == sda_in) |=> (tick == 5'd0 && ack_pend));

    p_tick_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= 5'd16);

    p_no_stb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(sda_out) && $stable(tick) && $stable(ack_pend)));

endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_q    (scl_q),
    .sda_out  (sda_out),
    .ack_pend (ack_pend),
    .tick     (tick)
);

// File: tb/eep_i2c_target_bench.sv
// Self-checking bench for eep_i2c_target: a table of read addresses walked
// by one loop, then directed cases for reset, idle, invalid edges, stop and restart.
module eep_i2c_target_bench;

    localparam logic [7:0] SEED   = 8'h5A;
    localparam int         N_VEC  = 8;
    localparam logic [7:0] VEC_ADDR [N_VEC] = '{8'h00, 8'h01, 8'h7F, 8'h80,
                                                8'hFF, 8'h3C, 8'hA5, 8'h10};
    localparam logic [7:0] CMD_WR = 8'hA0;
    localparam logic [7:0] CMD_RD = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eep_i2c_target u_eep_i2c_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .sda_out (sda_out)
    );

    function automatic logic [7:0] img(logic [7:0] a);
        return 8'((int'(a) * 37 + int'(SEED)) % 256);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host write; the stored result is visible at the returning negedge.
    task automatic put(logic c, logic d);
        @(negedge clk);
        wr_stb = 1'b1; scl_in = c; sda_in = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic clk_bit(logic b, output logic seen);
        put(1'b0, b);
        put(1'b1, b);
        seen = sda_out;
    endtask

    // Full transaction with optional invalid edge, stop or restart injection.
    task automatic tx(input logic [7:0] cmd, input logic [7:0] addr,
                      input int bad_at, input int stop_at, input bit restart,
                      output logic [7:0] rd);
        logic seen;
        put(1'b0, 1'b1);
        put(1'b1, 1'b1);
        put(1'b1, 1'b0);
        if (restart) begin
            for (int k = 0; k < 3; k++) clk_bit(1'b1, seen);
            put(1'b1, 1'b0);   // R2 restart from SCL high, SDA high
        end
        for (int i = 0; i < 8; i++) begin
            if (i == bad_at) begin
                put(1'b0, ~cmd[7-i]);
                put(1'b1, cmd[7-i]);   // R4 rise with SDA change
            end
            clk_bit(cmd[7-i], seen);
            if (i == 7) check("R9 command bit echo before ack", seen, cmd[0]);
            if (i == stop_at) put(1'b1, 1'b1);   // R8 stop after a 0 bit
        end
        clk_bit(1'b1, seen);
        check("R5 command ack low", seen, 1'b0);
        for (int i = 0; i < 8; i++) begin
            clk_bit(addr[7-i], seen);
            rd[7-i] = seen;
        end
        clk_bit(1'b1, seen);
        check("R5/R7 address ack low", seen, 1'b0);
        put(1'b0, 1'b1);
    endtask

    initial begin
        logic [7:0] rd;
        logic       seen;
        logic       any_low;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sda_out", sda_out, 1'b1);

        // R11: input motion without strobe
        for (int k = 0; k < 4; k++) begin
            scl_in = k[0]; sda_in = k[1];
            @(negedge clk);
        end
        check("R11 no strobe no change", sda_out, 1'b1);

        // R9: stored host level while idle
        clk_bit(1'b0, seen);
        check("R9 idle level follows host", seen, 1'b0);

        // R3: clocking while idle gives no acknowledge
        any_low = 1'b0;
        for (int k = 0; k < 10; k++) begin
            clk_bit(1'b1, seen);
            if (!seen) any_low = 1'b1;
        end
        check("R3 idle clocks give no ack", any_low, 1'b0);

        // R6: first read after reset shows the zero data register
        tx(CMD_RD, 8'h11, -1, -1, 1'b0, rd);
        check("R6 read after reset gives zero", rd, 8'h00);
        // The line is released after the ack, so a 1 reads back as 1.
        put(1'b0, 1'b1);
        check("R9 line released after ack", sda_out, 1'b1);

        // Table: fetch by write command, then read back during the next transaction.
        for (int v = 0; v < N_VEC; v++) begin
            tx(CMD_WR, VEC_ADDR[v], -1, -1, 1'b0, rd);
            check("R9 write-mode address echo", rd, VEC_ADDR[v]);
            tx(CMD_RD, ~VEC_ADDR[v], -1, -1, 1'b0, rd);
            check("R6/R10 read data MSB first", rd, img(VEC_ADDR[v]));
        end
        // The last read transaction fetched ~0x10 = 0xEF.
        tx(CMD_RD, 8'h00, -1, -1, 1'b0, rd);
        check("R7 fetch at read-phase address", rd, img(8'hEF));

        // R7: after the final ack the block is idle
        any_low = 1'b0;
        for (int k = 0; k < 10; k++) begin
            clk_bit(1'b1, seen);
            if (!seen) any_low = 1'b1;
        end
        check("R7 idle after fetch", any_low, 1'b0);

        // R4: invalid edge inside the command byte is not counted
        tx(CMD_RD, 8'h5C, 3, -1, 1'b0, rd);
        check("R4 read after invalid edge", rd, img(8'h00));

        // R8: stop in the middle of the command leaves the count intact
        tx(CMD_WR, 8'h42, -1, 1, 1'b0, rd);
        check("R8 address echo after stop", rd, 8'h42);

        // R2: restart clears the partial command
        tx(CMD_RD, 8'h99, -1, -1, 1'b1, rd);
        check("R2 restart then read", rd, img(8'h42));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule